// File: doc/BRIEF.md
# Instruction Address Breakpoint Unit

This block watches the program counter of the instruction about to execute and raises a debug-break request when the address matches one of a small number of armed breakpoint registers. It holds `N` address registers and one enable mask. Software loads both through a simple write port. A comparator only counts when its enable bit is set.

All matching is suppressed while the current interrupt level is at or above a configured debug level. Every comparison is qualified by a PC-valid strobe. The result appears one clock later as a per-comparator hit vector and a single break request.

A small report state machine sits at the output and has three states:
- `ST_QUIET`: no compare, or a compare without a match.
- `ST_GATED`: a compare that the interrupt-level threshold blocked.
- `ST_BREAK`: a compare with at least one hit.

From any state, the next state is chosen by the current cycle's inputs:
- no strobe leads to `ST_QUIET`;
- a strobe at a blocked level leads to `ST_GATED`;
- a strobe with a match leads to `ST_BREAK`;
- any other strobe leads to `ST_QUIET`.

Top module: `ibrk_unit`

## Requirements
- R1: After reset every address register and the enable mask are zero, `enable_q`, `hit_vec` and `brk_req` are zero, and a compare against PC 0 reports no hit.
- R2: A write with `wr_sel`=1 loads the enable mask. Bits at position N and above are forced to zero, and `enable_q` shows the stored mask zero-extended to 32 bits.
- R3: `hit_vec[i]` is set only when enable bit i is 1 and address register i equals `pc` exactly.
- R4: When `int_lvl` >= `dbg_lvl` in the cycle of a compare, `hit_vec` and `brk_req` are zero for that compare.
- R5: `hit_vec` and `brk_req` are registered: they reflect the compare strobed by `pc_valid` in the previous cycle, and they are zero after any cycle without `pc_valid`. `brk_req` equals the OR of `hit_vec`.
- R6: Rewriting the address of an enabled comparator (`wr_sel`=0, `wr_idx`=i) changes what it matches from the next compare on, with no need to toggle its enable bit.
- R7: A write and a compare in the same cycle use the register values from before the write.
- R8: An address write whose `wr_idx` is N or above changes no register.
- R9: Several comparators that match the same PC all set their `hit_vec` bits together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = address register, 1 = enable mask |
| wr_idx | input | IDXW | Comparator index for address writes |
| wr_data | input | 32 | Write data |
| pc_valid | input | 1 | Marks `pc` as the instruction about to execute |
| pc | input | AW | Program counter to compare |
| int_lvl | input | LVLW | Current interrupt level |
| dbg_lvl | input | LVLW | Configured debug level |
| enable_q | output | 32 | Stored enable mask, zero-extended |
| hit_vec | output | N | Per-comparator hits of the previous compare |
| brk_req | output | 1 | Debug-break request |

## Verification
The bench builds the block with N=3, AW=32 and LVLW=4.

Three comparators is not a power of two, so the two-bit index can address a comparator that does not exist. This lets the bench show that such a write is dropped. The enable-mask truncation is visible on the ports, because bits 3 to 31 of a write can be seen to vanish.

With three comparators, two registers can share one address, which exercises simultaneous hits. The four-bit levels allow the threshold to be tested just below, at, and above the debug level.

// File: rtl/ibrk_pkg.sv
package ibrk_pkg;

    typedef enum logic {
        WR_ADDR   = 1'b0,
        WR_ENABLE = 1'b1
    } wr_target_e;

    typedef enum logic [1:0] {
        ST_QUIET = 2'd0,
        ST_GATED = 2'd1,
        ST_BREAK = 2'd2
    } rpt_state_e;

endpackage

// File: rtl/ibrk_regs.sv
module ibrk_regs
    import ibrk_pkg::*;
#(
    parameter int N    = 4,
    parameter int AW   = 32,
    parameter int IDXW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [IDXW-1:0]   wr_idx,
    input  logic [31:0]       wr_data,
    output logic [N-1:0]      en_q,
    output logic [N*AW-1:0]   addr_flat
);

    // Enable mask: only the low N bits of a write are kept.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en && wr_target_e'(wr_sel) == WR_ENABLE) begin
            en_q <= wr_data[N-1:0];
        end
    end

    // Address registers: an index that names no comparator matches no slot.
    for (genvar i = 0; i < N; i++) begin : g_addr
        logic [AW-1:0] a_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                a_q <= '0;
            end else if (wr_en && wr_target_e'(wr_sel) == WR_ADDR &&
                         {1'b0, wr_idx} == (IDXW+1)'(i)) begin
                a_q <= wr_data[AW-1:0];
            end
        end

        assign addr_flat[i*AW +: AW] = a_q;
    end

endmodule

// File: rtl/ibrk_match.sv
module ibrk_match #(
    parameter int N    = 4,
    parameter int AW   = 32,
    parameter int LVLW = 4
) (
    input  logic [N-1:0]     en_q,
    input  logic [N*AW-1:0]  addr_flat,
    input  logic [AW-1:0]    pc,
    input  logic [LVLW-1:0]  int_lvl,
    input  logic [LVLW-1:0]  dbg_lvl,
    output logic [N-1:0]     raw_hit,
    output logic             gate_open
);

    // Breakpoints may fire only below the debug level.
    assign gate_open = (int_lvl < dbg_lvl);

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign raw_hit[i] = en_q[i] && (addr_flat[i*AW +: AW] == pc);
    end

endmodule

// File: rtl/ibrk_report.sv
module ibrk_report
    import ibrk_pkg::*;
#(
    parameter int N = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pc_valid,
    input  logic          gate_open,
    input  logic [N-1:0]  raw_hit,
    output logic [N-1:0]  hit_vec,
    output logic          brk_req
);

    rpt_state_e state_q, state_d;

    always_comb begin
        state_d = ST_QUIET;
        unique case (state_q)
            ST_QUIET: begin
                if (pc_valid && !gate_open)  state_d = ST_GATED;
                else if (pc_valid && |raw_hit) state_d = ST_BREAK;
                else                         state_d = ST_QUIET;
            end
            ST_GATED: begin
                if (!pc_valid)               state_d = ST_QUIET;
                else if (!gate_open)         state_d = ST_GATED;
                else if (|raw_hit)           state_d = ST_BREAK;
                else                         state_d = ST_QUIET;
            end
            ST_BREAK: begin
                if (!pc_valid)               state_d = ST_QUIET;
                else if (!gate_open)         state_d = ST_GATED;
                else if (|raw_hit)           state_d = ST_BREAK;
                else                         state_d = ST_QUIET;
            end
            default:                         state_d = ST_QUIET;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    // Output register: hits are captured only on entry to ST_BREAK.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  hit_vec <= '0;
        else if (state_d == ST_BREAK) hit_vec <= raw_hit;
        else                         hit_vec <= '0;
    end

    assign brk_req = (state_q == ST_BREAK);

endmodule

// File: rtl/ibrk_unit.sv
module ibrk_unit
    import ibrk_pkg::*;
#(
    parameter int N    = 4,
    parameter int AW   = 32,
    parameter int LVLW = 4,
    localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [IDXW-1:0]  wr_idx,
    input  logic [31:0]      wr_data,
    input  logic             pc_valid,
    input  logic [AW-1:0]    pc,
    input  logic [LVLW-1:0]  int_lvl,
    input  logic [LVLW-1:0]  dbg_lvl,
    output logic [31:0]      enable_q,
    output logic [N-1:0]     hit_vec,
    output logic             brk_req
);

    logic [N-1:0]    en_q;
    logic [N*AW-1:0] addr_flat;
    logic [N-1:0]    raw_hit;
    logic            gate_open;

    ibrk_regs #(.N(N), .AW(AW), .IDXW(IDXW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .en_q     (en_q),
        .addr_flat(addr_flat)
    );

    ibrk_match #(.N(N), .AW(AW), .LVLW(LVLW)) u_match (
        .en_q     (en_q),
        .addr_flat(addr_flat),
        .pc       (pc),
        .int_lvl  (int_lvl),
        .dbg_lvl  (dbg_lvl),
        .raw_hit  (raw_hit),
        .gate_open(gate_open)
    );

    ibrk_report #(.N(N)) u_report (
        .clk      (clk),
        .rst_n    (rst_n),
        .pc_valid (pc_valid),
        .gate_open(gate_open),
        .raw_hit  (raw_hit),
        .hit_vec  (hit_vec),
        .brk_req  (brk_req)
    );

    assign enable_q = 32'(en_q);

endmodule

// File: rtl/ibrk_check.sv
module ibrk_check #(
    parameter int N    = 4,
    parameter int LVLW = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pc_valid,
    input logic [LVLW-1:0]  int_lvl,
    input logic [LVLW-1:0]  dbg_lvl,
    input logic [31:0]      enable_q,
    input logic [N-1:0]     hit_vec,
    input logic             brk_req
);

    assert_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_q >> N) == 32'd0);

    assert_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (hit_vec & ~$past(enable_q[N-1:0])) == '0);

    assert_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_valid && int_lvl >= dbg_lvl) |=> (hit_vec == '0 && !brk_req));

    assert_or_R5: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req == (|hit_vec));

    assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_valid |=> (hit_vec == '0));

endmodule

bind ibrk_unit ibrk_check #(.N(N), .LVLW(LVLW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pc_valid(pc_valid),
    .int_lvl (int_lvl),
    .dbg_lvl (dbg_lvl),
    .enable_q(enable_q),
    .hit_vec (hit_vec),
    .brk_req (brk_req)
);

// File: tb/sim_ibrk_unit.sv
`timescale 1ns/1ps
module sim_ibrk_unit;

    localparam int N = 3, AW = 32, LVLW = 4, IDXW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0, wr_sel = 1'b0;
    logic [IDXW-1:0] wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic pc_valid = 1'b0;
    logic [AW-1:0] pc = '0;
    logic [LVLW-1:0] int_lvl = '0, dbg_lvl = 4'd5;
    logic [31:0] enable_q;
    logic [N-1:0] hit_vec;
    logic brk_req;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    ibrk_unit #(.N(N), .AW(AW), .LVLW(LVLW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_idx(wr_idx), .wr_data(wr_data), .pc_valid(pc_valid), .pc(pc),
        .int_lvl(int_lvl), .dbg_lvl(dbg_lvl), .enable_q(enable_q),
        .hit_vec(hit_vec), .brk_req(brk_req)
    );

    // Vector table: pc, int_lvl, expected hit_vec (enable=3'b011, dbg_lvl=5)
    localparam int NV = 6;
    localparam logic [AW+LVLW+N-1:0] VEC [NV] = '{
        {32'h0000_0100, 4'd0, 3'b001},
        {32'h0000_0200, 4'd4, 3'b010},
        {32'h0000_0300, 4'd0, 3'b000},
        {32'h0000_0100, 4'd5, 3'b000},
        {32'h0000_0200, 4'd9, 3'b000},
        {32'h0000_0101, 4'd0, 3'b000}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic sel, logic [IDXW-1:0] idx, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // One compare; outputs sampled at the next falling edge.
    task automatic cmp(logic [AW-1:0] p, logic [LVLW-1:0] lvl,
                       logic [N-1:0] exp, string req);
        @(negedge clk);
        pc_valid = 1'b1; pc = p; int_lvl = lvl;
        @(negedge clk);
        pc_valid = 1'b0;
        check({req, " hit"}, 32'(hit_vec), 32'(exp));
        check({req, " R5 brk"}, 32'(brk_req), 32'(|exp));
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 enable", enable_q, 32'd0);
        check("R1 hit", 32'(hit_vec), 32'd0);
        check("R1 brk", 32'(brk_req), 32'd0);
        rst_n = 1'b1;
        cmp(32'h0, 4'd0, 3'b000, "R1");

        wr(1'b0, 2'd0, 32'h100);
        wr(1'b0, 2'd1, 32'h200);
        wr(1'b0, 2'd2, 32'h100);
        wr(1'b1, 2'd0, 32'h3);
        for (int k = 0; k < NV; k++) begin
            cmp(VEC[k][AW+LVLW+N-1 -: AW], VEC[k][LVLW+N-1 -: LVLW],
                VEC[k][N-1:0], "R3/R4 table");
        end
        // R4 boundary: level one below debug level still fires
        cmp(32'h200, 4'd4, 3'b010, "R4 below");

        // R2: bits at N and above dropped
        wr(1'b1, 2'd0, 32'hFFFF_FFFF);
        check("R2 mask", enable_q, 32'h7);
        // R9: simultaneous hits
        cmp(32'h100, 4'd0, 3'b101, "R9");

        // R8: index 3 does not exist
        wr(1'b0, 2'd3, 32'h300);
        cmp(32'h300, 4'd0, 3'b000, "R8 none");
        cmp(32'h100, 4'd0, 3'b101, "R8 others");
        cmp(32'h200, 4'd0, 3'b010, "R8 slot1");

        // R6: rewrite enabled comparator
        wr(1'b0, 2'd1, 32'h240);
        cmp(32'h240, 4'd0, 3'b010, "R6 new");
        cmp(32'h200, 4'd0, 3'b000, "R6 old");

        // R7: write and compare in the same cycle
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b0; wr_idx = 2'd0; wr_data = 32'h500;
        pc_valid = 1'b1; pc = 32'h100; int_lvl = 4'd0;
        @(negedge clk);
        wr_en = 1'b0; pc_valid = 1'b0;
        check("R7 old value", 32'(hit_vec), 32'b101);
        cmp(32'h500, 4'd0, 3'b001, "R7 new");
        cmp(32'h100, 4'd0, 3'b100, "R7 after");

        // R5: no strobe -> outputs clear the next cycle
        @(negedge clk);
        check("R5 idle hit", 32'(hit_vec), 32'd0);
        check("R5 idle brk", 32'(brk_req), 32'd0);

        // R3: disabled comparators never hit
        wr(1'b1, 2'd0, 32'h0);
        cmp(32'h500, 4'd0, 3'b000, "R3 disabled");

        done = 1'b1;
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            report();
        end
    end

endmodule